// File: doc/BRIEF.md
# Debug Freeze Signal Controller

This block drives the processor-wide freeze line that a software monitor debugger relies on while hardware debug mode is switched off. The core reports debug-worthy events as single-cycle pulses, one per cause. Each pulse is recorded in a sticky cause register. When a recorded event also has its bit set in the event enable vector, freeze is raised. Freeze then stays up until the monitor has cleared the cause register and executed a return-from-interrupt.

Software clears the cause register by reading it in a clearing context. The core turns that read into a clear strobe for this block. Because freeze drops only on a return that finds the cause register empty, a monitor can enter and return several times while still holding recorded causes, and the freeze line does not move. The monitor clears the causes just before its final return, and that return releases freeze.

The same freeze value is presented on an internal output for on-chip modules and on an external pin output.

Top module: `frz_ctrl`

## Requirements
- R1: An event pulse on bit i of `evt_pulse_i` sets bit i of `cause_o` at the next clock edge. A set cause bit holds until it is cleared.
- R2: A high `cause_clr_i` clears every bit of `cause_o` at the next edge. If a bit's event pulse arrives in the same cycle as the clear, that bit ends up set.
- R3: While `hwdbg_en_i` is low, an event whose bit is set in `evt_enable_i` raises `freeze_o` at the next edge.
- R4: An event whose enable bit is zero is recorded in `cause_o` but does not raise `freeze_o`.
- R5: While `hwdbg_en_i` is high, events do not raise `freeze_o`. They are still recorded in `cause_o`.
- R6: A `rfi_i` pulse in a cycle where `cause_o` is nonzero leaves `freeze_o` high. Any number of such returns may occur.
- R7: A `rfi_i` pulse in a cycle where `cause_o` is all zero drops `freeze_o` at the next edge, provided no enabled event arrives in that cycle.
- R8: If an enabled event arrives in the same cycle as a return that would otherwise release freeze, `freeze_o` stays high.
- R9: `freeze_pin_o` equals `freeze_o` in every cycle.
- R10: After reset, `freeze_o` is low and `cause_o` is zero.
- R11: Freeze changes only as stated above. Without a qualifying return it stays high. Without an enabled event it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hwdbg_en_i | input | 1 | Hardware debug mode enabled; blocks freeze assertion |
| evt_pulse_i | input | NUM_EVT | One-cycle event cause pulses |
| evt_enable_i | input | NUM_EVT | Per-cause freeze enable bits |
| cause_clr_i | input | 1 | Clear strobe from a clearing read of the cause register |
| rfi_i | input | 1 | Return-from-interrupt executed |
| cause_o | output | NUM_EVT | Sticky cause register |
| freeze_o | output | 1 | Internal freeze signal |
| freeze_pin_o | output | 1 | External freeze pin |

## Verification
The bound checker checks the following on every cycle:
- the sticky setting of cause bits and the set-over-clear priority;
- the rise of freeze after an enabled event;
- freeze holding through returns that find recorded causes;
- the release on a return that finds an empty cause register;
- the rule that freeze cannot rise without an enabled event.

Other behaviour appears only in the bench's scenarios:
- a monitor that returns several times before clearing;
- recording of disabled events without freeze;
- suppression of freeze while hardware debug mode is on;
- an event that collides with the final return;
- the equality of the pin and the internal signal.

// File: rtl/frz_pkg.sv
package frz_pkg;
   localparam int unsigned FRZ_MAX_EVT = 32;

   typedef enum logic {
      FRZ_RUN  = 1'b0,
      FRZ_HALT = 1'b1
   } frz_state_e;
endpackage

// File: rtl/frz_cause_reg.sv
module frz_cause_reg #(
   parameter int unsigned NUM_EVT = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_EVT-1:0] set_i,
   input  logic               clr_i,
   output logic [NUM_EVT-1:0] cause_o,
   output logic               empty_o
);
   for (genvar g = 0; g < NUM_EVT; g++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            bit_q <= 1'b0;
         end else if (set_i[g]) begin
            bit_q <= 1'b1;
         end else if (clr_i) begin
            bit_q <= 1'b0;
         end
      end
      assign cause_o[g] = bit_q;
   end

   assign empty_o = (cause_o == '0);
endmodule

// File: rtl/frz_event_qual.sv
module frz_event_qual #(
   parameter int unsigned NUM_EVT = 8
) (
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic [NUM_EVT-1:0] enable_i,
   input  logic               hwdbg_en_i,
   output logic               trig_o
);
   logic [NUM_EVT-1:0] hit;

   always_comb begin
      hit    = evt_i & enable_i;
      trig_o = (|hit) & ~hwdbg_en_i;
   end
endmodule

// File: rtl/frz_state.sv
module frz_state
   import frz_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic trig_i,
   input  logic rfi_i,
   input  logic cause_empty_i,
   output logic freeze_o
);
   frz_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (trig_i) begin
         state_d = FRZ_HALT;
      end else if (rfi_i && cause_empty_i) begin
         state_d = FRZ_RUN;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= FRZ_RUN;
      end else begin
         state_q <= state_d;
      end
   end

   assign freeze_o = (state_q == FRZ_HALT);
endmodule

// File: rtl/frz_ctrl.sv
module frz_ctrl
   import frz_pkg::*;
#(
   parameter int unsigned NUM_EVT = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               hwdbg_en_i,
   input  logic [NUM_EVT-1:0] evt_pulse_i,
   input  logic [NUM_EVT-1:0] evt_enable_i,
   input  logic               cause_clr_i,
   input  logic               rfi_i,
   output logic [NUM_EVT-1:0] cause_o,
   output logic               freeze_o,
   output logic               freeze_pin_o
);
   initial begin
      if (NUM_EVT < 1 || NUM_EVT > FRZ_MAX_EVT) begin
         $error("frz_ctrl: NUM_EVT out of range");
      end
   end

   logic trig;
   logic cause_empty;
   logic frz;

   frz_cause_reg #(.NUM_EVT(NUM_EVT)) cause_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (evt_pulse_i),
      .clr_i   (cause_clr_i),
      .cause_o (cause_o),
      .empty_o (cause_empty)
   );

   frz_event_qual #(.NUM_EVT(NUM_EVT)) qual_i (
      .evt_i      (evt_pulse_i),
      .enable_i   (evt_enable_i),
      .hwdbg_en_i (hwdbg_en_i),
      .trig_o     (trig)
   );

   frz_state state_i (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .trig_i        (trig),
      .rfi_i         (rfi_i),
      .cause_empty_i (cause_empty),
      .freeze_o      (frz)
   );

   assign freeze_o     = frz;
   assign freeze_pin_o = frz;
endmodule

// File: rtl/frz_ctrl_chk.sv
module frz_ctrl_chk #(
   parameter int unsigned NUM_EVT = 8
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               hwdbg_en_i,
   input logic [NUM_EVT-1:0] evt_pulse_i,
   input logic [NUM_EVT-1:0] evt_enable_i,
   input logic               cause_clr_i,
   input logic               rfi_i,
   input logic [NUM_EVT-1:0] cause_o,
   input logic               freeze_o,
   input logic               freeze_pin_o
);
   logic enabled_hit;
   assign enabled_hit = (|(evt_pulse_i & evt_enable_i)) && !hwdbg_en_i;

   p_evt_sets_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_pulse_i != '0) |=> ((cause_o & $past(evt_pulse_i)) == $past(evt_pulse_i)));

   p_cause_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cause_clr_i) |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

   p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cause_clr_i |=> (cause_o == $past(evt_pulse_i)));

   p_freeze_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      enabled_hit |=> freeze_o);

   p_hold_on_busy_rfi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (freeze_o && rfi_i && cause_o != '0) |=> freeze_o);

   p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rfi_i && cause_o == '0 && !enabled_hit) |=> !freeze_o);

   p_no_spurious_rise_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!freeze_o && !enabled_hit) |=> !freeze_o);

   p_no_spurious_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (freeze_o && !rfi_i) |=> freeze_o);
endmodule

bind frz_ctrl frz_ctrl_chk #(.NUM_EVT(NUM_EVT)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .hwdbg_en_i   (hwdbg_en_i),
   .evt_pulse_i  (evt_pulse_i),
   .evt_enable_i (evt_enable_i),
   .cause_clr_i  (cause_clr_i),
   .rfi_i        (rfi_i),
   .cause_o      (cause_o),
   .freeze_o     (freeze_o),
   .freeze_pin_o (freeze_pin_o)
);

// File: tb/frz_ctrl_tb_top.sv
module frz_ctrl_tb_top;
   localparam int unsigned N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         hwdbg = 1'b0;
   logic [N-1:0] evt = '0;
   logic [N-1:0] en = '0;
   logic         clr = 1'b0;
   logic         rfi = 1'b0;
   logic [N-1:0] cause;
   logic         frz;
   logic         pin;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   frz_ctrl #(.NUM_EVT(N)) dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .hwdbg_en_i   (hwdbg),
      .evt_pulse_i  (evt),
      .evt_enable_i (en),
      .cause_clr_i  (clr),
      .rfi_i        (rfi),
      .cause_o      (cause),
      .freeze_o     (frz),
      .freeze_pin_o (pin)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one cycle of stimulus, then settle just past the edge
   task automatic cyc(input logic [N-1:0] e, input logic c, input logic r);
      @(negedge clk);
      evt = e; clr = c; rfi = r;
      @(posedge clk);
      #1;
      evt = '0; clr = 1'b0; rfi = 1'b0;
      chk("R9", {31'd0, pin}, {31'd0, frz});
   endtask

   task automatic do_reset();
      rst_n = 1'b0; hwdbg = 1'b0; en = '0;
      repeat (2) @(posedge clk);
      #1;
      chk("R10", {31'd0, frz}, 32'd0);
      chk("R10", {24'd0, cause}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_record_and_clear();
      do_reset();
      cyc(8'h05, 1'b0, 1'b0);
      chk("R1", {24'd0, cause}, 32'h05);
      cyc(8'h00, 1'b0, 1'b0);
      chk("R1", {24'd0, cause}, 32'h05);
      cyc(8'h00, 1'b1, 1'b0);
      chk("R2", {24'd0, cause}, 32'h00);
      cyc(8'h00, 1'b0, 1'b0);
      cyc(8'h0C, 1'b0, 1'b0);
      cyc(8'h04, 1'b1, 1'b0);
      chk("R2", {24'd0, cause}, 32'h04);
   endtask

   task automatic t_disabled_event();
      do_reset();
      en = 8'h01;
      cyc(8'h80, 1'b0, 1'b0);
      chk("R4", {31'd0, frz}, 32'd0);
      chk("R4", {24'd0, cause}, 32'h80);
      repeat (3) cyc(8'h00, 1'b0, 1'b0);
      chk("R11", {31'd0, frz}, 32'd0);
   endtask

   task automatic t_hwdbg_block();
      do_reset();
      en = 8'hFF; hwdbg = 1'b1;
      cyc(8'h10, 1'b0, 1'b0);
      chk("R5", {31'd0, frz}, 32'd0);
      chk("R5", {24'd0, cause}, 32'h10);
      hwdbg = 1'b0;
   endtask

   task automatic t_nested_monitor();
      do_reset();
      en = 8'h02;
      cyc(8'h02, 1'b0, 1'b0);
      chk("R3", {31'd0, frz}, 32'd1);
      repeat (4) cyc(8'h00, 1'b0, 1'b0);
      chk("R11", {31'd0, frz}, 32'd1);
      for (int i = 0; i < 3; i++) begin
         cyc(8'h00, 1'b0, 1'b1);
         chk("R6", {31'd0, frz}, 32'd1);
      end
      cyc(8'h00, 1'b1, 1'b0);
      chk("R2", {24'd0, cause}, 32'd0);
      chk("R11", {31'd0, frz}, 32'd1);
      cyc(8'h00, 1'b0, 1'b1);
      chk("R7", {31'd0, frz}, 32'd0);
   endtask

   task automatic t_clear_with_rfi_same_cycle();
      // cause still set when the return executes: freeze holds
      do_reset();
      en = 8'h01;
      cyc(8'h01, 1'b0, 1'b0);
      cyc(8'h00, 1'b1, 1'b1);
      chk("R6", {31'd0, frz}, 32'd1);
      chk("R2", {24'd0, cause}, 32'd0);
      cyc(8'h00, 1'b0, 1'b1);
      chk("R7", {31'd0, frz}, 32'd0);
   endtask

   task automatic t_event_on_release();
      do_reset();
      en = 8'h40;
      cyc(8'h40, 1'b0, 1'b0);
      cyc(8'h00, 1'b1, 1'b0);
      cyc(8'h40, 1'b0, 1'b1);
      chk("R8", {31'd0, frz}, 32'd1);
      chk("R1", {24'd0, cause}, 32'h40);
   endtask

   initial begin
      t_record_and_clear();
      t_disabled_event();
      t_hwdbg_block();
      t_nested_monitor();
      t_clear_with_rfi_same_cycle();
      t_event_on_release();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule